// File: doc/BRIEF.md
# Interconnect Traffic Source and Sink

This block stands in for the cache and directory endpoints when an on-chip interconnect is exercised on its own. On the request side it takes core accesses and answers every one as an immediate hit. It tracks no line state. Each access becomes one message on a virtual network picked by the access kind. The message carries a size class that also follows from the kind, and a destination directory taken from the line-index bits of the address.

On the receive side it has three virtual-network inputs that are always ready. Every message that arrives is popped and nothing is ever sent back. A saturating counter per virtual network records the arrivals, so a test harness can compare what was injected with what came out of the fabric.

The request path is purely combinational. An access is held off only while the virtual network it selects is not ready.

Top module: `vnet_traffic_top`

## Requirements
- R1: A request of kind load (code 0) raises only `tx_valid_o[0]` and drives a size of 8 bytes.
- R2: A request of kind instruction fetch (code 1) raises only `tx_valid_o[1]` and drives a size of 8 bytes.
- R3: A request of kind store (code 2) raises only `tx_valid_o[2]` and drives a size of 72 bytes.
- R4: For kinds 0 to 2, `req_ready_o` equals the ready input of the selected virtual network. `req_hit_o` is high exactly when `req_valid_i` and `req_ready_o` are both high, in the same cycle. At most one bit of `tx_valid_o` is ever high.
- R5: `tx_dest_o` equals the MAP_BITS-wide address field starting at bit log2(LINE_BYTES), taken modulo NUM_DIRS. Address bits outside that field have no effect.
- R6: Kind code 3 is reserved. It is acknowledged as a hit at once and raises no `tx_valid_o` bit.
- R7: `rx_ready_o` is all ones. Each virtual-network counter in `rx_count_o` (network v at bits v*CNT_W upward) rises by one after every clock edge at which its `rx_valid_i` bit is high. The counters are independent of each other, including when several inputs are high together.
- R8: The counters are zero after reset. Each counter stops at 2^CNT_W-1 and holds that value from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Core request present |
| req_kind_i | input | 2 | 0 load, 1 instruction fetch, 2 store, 3 reserved |
| req_addr_i | input | ADDR_W | Request address |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_hit_o | output | 1 | Request accepted and answered as a hit |
| tx_valid_o | output | 3 | Message valid, one bit per virtual network |
| tx_ready_i | input | 3 | Interconnect ready, one bit per virtual network |
| tx_dest_o | output | DEST_W | Destination directory index |
| tx_size_o | output | 7 | Message size in bytes |
| rx_valid_i | input | 3 | Arriving message, one bit per virtual network |
| rx_ready_o | output | 3 | Sink ready, one bit per virtual network |
| rx_count_o | output | 3*CNT_W | Received-message counters, packed by virtual network |

## Verification
The bench builds the block with NUM_DIRS of 3, so the modulo step in the destination map is not a plain bit slice. Field values such as 254 and 255 then show whether the wrap is correct. CNT_W is 4, so a counter reaches its saturation value of 15 after a short burst and R8 can be observed directly. LINE_BYTES of 64 and MAP_BITS of 8 leave address bits both below and above the field, which lets the bench show that those bits are ignored.

// File: rtl/vnet_pkg.sv
package vnet_pkg;
  localparam int unsigned NUM_VNETS = 3;
  localparam int unsigned SIZE_W    = 7;

  localparam logic [SIZE_W-1:0] CTRL_BYTES = 7'd8;
  localparam logic [SIZE_W-1:0] DATA_BYTES = 7'd72;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RSVD  = 2'd3
  } req_kind_e;

  function automatic logic [NUM_VNETS-1:0] kind_to_vnet(req_kind_e kind);
    case (kind)
      KIND_LOAD:  return 3'b001;
      KIND_FETCH: return 3'b010;
      KIND_STORE: return 3'b100;
      default:    return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/vnet_dir_map.sv
module vnet_dir_map #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned MAP_BITS   = 8,
  parameter int unsigned NUM_DIRS   = 4,
  parameter int unsigned DEST_W     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DEST_W-1:0] dest_o
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);

  logic [MAP_BITS-1:0] field;
  logic                unused_addr;

  assign field       = addr_i[OFF_W +: MAP_BITS];
  assign unused_addr = ^{addr_i[OFF_W-1:0], addr_i[ADDR_W-1:OFF_W+MAP_BITS]};
  assign dest_o      = DEST_W'(field % MAP_BITS'(NUM_DIRS));
endmodule

// File: rtl/vnet_source.sv
module vnet_source
  import vnet_pkg::*;
(
  input  logic                  req_valid_i,
  input  logic [1:0]            req_kind_i,
  output logic                  req_ready_o,
  output logic                  req_hit_o,
  output logic [NUM_VNETS-1:0]  tx_valid_o,
  input  logic [NUM_VNETS-1:0]  tx_ready_i,
  output logic [SIZE_W-1:0]     tx_size_o
);
  req_kind_e             kind;
  logic [NUM_VNETS-1:0]  sel;

  assign kind = req_kind_e'(req_kind_i);
  assign sel  = kind_to_vnet(kind);

  // reserved kind: accepted and dropped
  assign req_ready_o = (kind == KIND_RSVD) ? 1'b1 : |(sel & tx_ready_i);
  assign req_hit_o   = req_valid_i & req_ready_o;
  assign tx_valid_o  = req_valid_i ? sel : '0;
  assign tx_size_o   = (kind == KIND_STORE) ? DATA_BYTES : CTRL_BYTES;
endmodule

// File: rtl/vnet_sink.sv
module vnet_sink #(
  parameter int unsigned NUM_VNETS = 3,
  parameter int unsigned CNT_W     = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_VNETS-1:0]       valid_i,
  output logic [NUM_VNETS-1:0]       ready_o,
  output logic [NUM_VNETS*CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign ready_o = '1;

  for (genvar v = 0; v < NUM_VNETS; v++) begin : g_vnet
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cnt_q <= '0;
      else if (valid_i[v] && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o[v*CNT_W +: CNT_W] = cnt_q;

    assert_count_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[v] && count_o[v*CNT_W +: CNT_W] != CNT_MAX)
        |=> count_o[v*CNT_W +: CNT_W] == $past(count_o[v*CNT_W +: CNT_W]) + 1'b1);

    assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_i[v] || count_o[v*CNT_W +: CNT_W] == CNT_MAX) |=> $stable(count_o[v*CNT_W +: CNT_W]));
  end

  assert_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni) &ready_o);
endmodule

// File: rtl/vnet_traffic_top.sv
module vnet_traffic_top
  import vnet_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned MAP_BITS   = 8,
  parameter int unsigned NUM_DIRS   = 4,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned DEST_W    = (NUM_DIRS > 1) ? $clog2(NUM_DIRS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [1:0]                 req_kind_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  output logic                       req_ready_o,
  output logic                       req_hit_o,
  output logic [2:0]                 tx_valid_o,
  input  logic [2:0]                 tx_ready_i,
  output logic [DEST_W-1:0]          tx_dest_o,
  output logic [6:0]                 tx_size_o,
  input  logic [2:0]                 rx_valid_i,
  output logic [2:0]                 rx_ready_o,
  output logic [3*CNT_W-1:0]         rx_count_o
);
  vnet_source i_source (
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_ready_o (req_ready_o),
    .req_hit_o   (req_hit_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_size_o   (tx_size_o)
  );

  vnet_dir_map #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .MAP_BITS   (MAP_BITS),
    .NUM_DIRS   (NUM_DIRS),
    .DEST_W     (DEST_W)
  ) i_dir_map (
    .addr_i (req_addr_i),
    .dest_o (tx_dest_o)
  );

  vnet_sink #(
    .NUM_VNETS (NUM_VNETS),
    .CNT_W     (CNT_W)
  ) i_sink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .ready_o (rx_ready_o),
    .count_o (rx_count_o)
  );

  assert_one_vnet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_valid_o));

  assert_ready_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i != 2'd3) |-> (req_ready_o == |(tx_valid_o & tx_ready_i)));

  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd0) |-> (tx_valid_o == 3'b001 && tx_size_o == 7'd8));

  assert_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd1) |-> (tx_valid_o == 3'b010 && tx_size_o == 7'd8));

  assert_store_size_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o[2] |-> tx_size_o == 7'd72);

  assert_dest_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_valid_o) |-> ({1'b0, tx_dest_o} < (DEST_W+1)'(NUM_DIRS)));

  assert_rsvd_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd3) |-> (tx_valid_o == 3'b000 && req_hit_o));
endmodule

// File: tb/test_vnet_traffic_top.sv
module test_vnet_traffic_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int NUM_DIRS   = 3;
  localparam int CNT_W      = 4;
  localparam int DEST_W     = 2;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              req_valid = 0;
  logic [1:0]        req_kind = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic              req_ready, req_hit;
  logic [2:0]        tx_valid;
  logic [2:0]        tx_ready = 3'b111;
  logic [DEST_W-1:0] tx_dest;
  logic [6:0]        tx_size;
  logic [2:0]        rx_valid = 0;
  logic [2:0]        rx_ready;
  logic [3*CNT_W-1:0] rx_count;

  int n_run = 0;
  int n_fail = 0;
  int exp_cnt [3] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  vnet_traffic_top #(
    .ADDR_W(ADDR_W), .LINE_BYTES(64), .MAP_BITS(8), .NUM_DIRS(NUM_DIRS), .CNT_W(CNT_W)
  ) i_vnet_traffic_top (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .req_hit_o(req_hit),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_dest_o(tx_dest), .tx_size_o(tx_size),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_count_o(rx_count)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_counts(string req);
    for (int v = 0; v < 3; v++)
      chk(req, $sformatf("count vnet%0d", v), rx_count[v*CNT_W +: CNT_W], exp_cnt[v]);
  endtask

  task automatic drive_req(logic [1:0] kind, logic [ADDR_W-1:0] addr, logic [2:0] rdy);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_addr = addr; tx_ready = rdy;
    #1;
  endtask

  task automatic t_reset;
    chk("R8", "count after reset", rx_count, 0);
    chk("R7", "rx_ready", rx_ready, 3'b111);
  endtask

  task automatic t_load;
    drive_req(2'd0, 32'h0000_1040, 3'b111);
    chk("R1", "load valid", tx_valid, 3'b001);
    chk("R1", "load size", tx_size, 8);
    chk("R4", "load hit", req_hit, 1);
  endtask

  task automatic t_fetch;
    drive_req(2'd1, 32'h0000_2080, 3'b111);
    chk("R2", "fetch valid", tx_valid, 3'b010);
    chk("R2", "fetch size", tx_size, 8);
    chk("R4", "fetch hit", req_hit, 1);
  endtask

  task automatic t_store;
    drive_req(2'd2, 32'h0000_30C0, 3'b111);
    chk("R3", "store valid", tx_valid, 3'b100);
    chk("R3", "store size", tx_size, 72);
    chk("R4", "store hit", req_hit, 1);
  endtask

  task automatic t_stall;
    drive_req(2'd0, 32'h0, 3'b110);
    chk("R4", "load stalled ready", req_ready, 0);
    chk("R4", "load stalled hit", req_hit, 0);
    chk("R4", "load stalled valid", tx_valid, 3'b001);
    drive_req(2'd0, 32'h0, 3'b001);
    chk("R4", "load released hit", req_hit, 1);
    drive_req(2'd2, 32'h0, 3'b011);
    chk("R4", "store stalled ready", req_ready, 0);
    drive_req(2'd1, 32'h0, 3'b101);
    chk("R4", "fetch stalled ready", req_ready, 0);
    @(negedge clk); req_valid = 0; #1;
    chk("R4", "idle valid", tx_valid, 0);
    chk("R4", "idle hit", req_hit, 0);
  endtask

  task automatic t_dest;
    int idx [6] = '{0, 1, 2, 5, 254, 255};
    for (int i = 0; i < 6; i++) begin
      logic [ADDR_W-1:0] a;
      a = (ADDR_W'(idx[i]) << 6) | 32'h0000_003F | (ADDR_W'(i) << 20);
      drive_req(2'(i % 3), a, 3'b111);
      chk("R5", $sformatf("dest idx %0d", idx[i]), tx_dest, ((a >> 6) & 255) % NUM_DIRS);
    end
  endtask

  task automatic t_rsvd;
    drive_req(2'd3, 32'h0000_0040, 3'b000);
    chk("R6", "reserved valid", tx_valid, 0);
    chk("R6", "reserved hit", req_hit, 1);
    @(negedge clk); req_valid = 0; tx_ready = 3'b111;
  endtask

  task automatic pulse_rx(logic [2:0] pat, int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      rx_valid = pat;
      for (int v = 0; v < 3; v++)
        if (pat[v] && exp_cnt[v] < (1 << CNT_W) - 1) exp_cnt[v]++;
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_sink_count;
    pulse_rx(3'b001, 2);
    chk_counts("R7");
    pulse_rx(3'b111, 3);
    chk_counts("R7");
    pulse_rx(3'b010, 1);
    chk_counts("R7");
  endtask

  task automatic t_sink_sat;
    pulse_rx(3'b100, 20);
    chk_counts("R8");
    chk("R8", "vnet2 saturated", rx_count[2*CNT_W +: CNT_W], 15);
    pulse_rx(3'b100, 2);
    chk("R8", "vnet2 holds", rx_count[2*CNT_W +: CNT_W], 15);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_load();
    t_fetch();
    t_store();
    t_stall();
    t_dest();
    t_rsvd();
    t_sink_count();
    t_sink_sat();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule